// File: doc/BRIEF.md
# Boosting Frequency Target Controller

This block turns activity readings from a bus monitor into a requested clock frequency, expressed in kHz. Each request starts from a `start` pulse and carries two event flags: one for sustained high activity and one for sustained low activity. It also carries the current moving average of the activity count. The controller keeps a boost term between requests. Sustained high activity grows the boost by a percentage plus a fixed step, up to the maximum frequency. Sustained low activity shrinks it by a percentage, and a boost that falls below half a step is cut to zero.

On every request the block also does three other jobs. It recomputes the enables for the monitor's two consecutive-event interrupts. It places a pair of average watermarks around the new average. It derives the target frequency from the average, scaled by the upward threshold, plus the boost. An optional dependency threshold ties this target to a floor frequency.

The arithmetic is a multi-cycle sequence. It uses one shared multiplier and one iterative restoring divider, and `busy`/`done` bracket each request. All results are committed together in the cycle that carries `done`.

Top module: `bt_target_ctrl`

## Requirements
- R1: A `start` seen while idle raises `busy` on the next cycle. All results (boost, target, enables, watermarks) change only in the single cycle in which `done` is high, and `done` lasts one cycle. A `start` given while `busy` is high is ignored and produces no further `done`.
- R2: An upward event sets both enables to 1. It replaces the boost with floor(boost·up_pct/100) + 16000.
- R3: If that upward result is greater than or equal to `fmax_i`, the boost becomes `fmax_i` and the above-enable is 0. The boost never exceeds `fmax_i`.
- R4: A downward event sets both enables to 1 and replaces the boost with floor(boost·dn_pct/100). If that value is below 8000, the boost becomes 0 and the below-enable is 0.
- R5: When both event flags are high, only the upward rule applies.
- R6: With no event flag, the boost keeps its value and the enables take the values of `en_above_i` and `en_below_i`.
- R7: When `dep_thr_i` is nonzero, the below-enable is forced to 1 if the average is at or above `dep_thr_i`. Otherwise it is forced to 0 if the new boost is 0. This overrides R2, R4 and R6.
- R8: With band = `band_i`·12, the high watermark is (avg + band) mod 2^W and the low watermark is max(avg, band) − band.
- R9: The target is floor(floor(avg/12)·floor(10000/up_thr)/100) + boost, saturated to 2^W−1.
- R10: When the average is at or above `dep_thr_i`, the target is raised to at least `floor_i`.
- R11: While `rst` is high, the boost and both watermarks are 0, both enables are 1, `done` and `busy` are 0, and the target follows `fcur_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one update |
| ev_up | input | 1 | Sustained-high activity event |
| ev_dn | input | 1 | Sustained-low activity event |
| en_above_i | input | 1 | Present above-enable of the monitor |
| en_below_i | input | 1 | Present below-enable of the monitor |
| avg_i | input | W | Average activity count |
| fmax_i | input | W | Maximum frequency (kHz) |
| fcur_i | input | W | Current frequency (kHz), reset value of the target |
| up_pct_i | input | PW | Growth coefficient in percent |
| dn_pct_i | input | PW | Decay coefficient in percent (at most 100) |
| up_thr_i | input | PW | Upward threshold in percent (nonzero) |
| band_i | input | PW | Watermark band frequency |
| dep_thr_i | input | W | Dependency threshold, 0 disables it |
| floor_i | input | W | Floor frequency for the dependency rule |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse as results are committed |
| target_o | output | W | Target frequency (kHz) |
| boost_o | output | W | Boost term (kHz) |
| en_above_o | output | 1 | New above-enable |
| en_below_o | output | 1 | New below-enable |
| wm_hi_o | output | W | Upper average watermark |
| wm_lo_o | output | W | Lower average watermark |

## Verification
`busy` is due one cycle after an accepted `start`. Every other result is due only on the cycle that carries `done`. That cycle comes a few hundred cycles later, and its exact position depends on whether an event flag skipped the boost division. The bench therefore does not count a fixed latency. It samples at falling edges, waits for the `done` pulse under a cycle bound, and compares every output in that same cycle against values computed from the requirements. While it waits, it also confirms that boost and target stay frozen. After a request it watches for a few hundred cycles to confirm that a `start` given mid-run produced no second pulse.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int unsigned STEP_KHZ  = 16000;
    localparam int unsigned HALF_STEP = STEP_KHZ / 2;
    localparam int unsigned PERIOD_MS = 12;
    localparam int unsigned PCT_BASE  = 100;
    localparam int unsigned COEF_NUM  = 10000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BMUL,
        ST_BDIV,
        ST_BUPD,
        ST_ADIV,
        ST_CDIV,
        ST_TMUL,
        ST_TDIV,
        ST_FIN
    } bt_state_e;

    typedef struct packed {
        logic above;
        logic below;
    } bt_en_t;

endpackage

// File: rtl/bt_mul.sv
module bt_mul #(
    parameter int W  = 32,
    parameter int PW = 16
) (
    input  logic [W-1:0]    a,
    input  logic [PW-1:0]   b,
    output logic [W+PW-1:0] p
);
    always_comb p = (W+PW)'(a) * (W+PW)'(b);
endmodule

// File: rtl/bt_div.sv
module bt_div #(
    parameter int DW   = 48,
    parameter int DENW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic [DW-1:0]   num,
    input  logic [DENW-1:0] den,
    output logic            rdy,
    output logic [DW-1:0]   quo
);
    localparam int CW = $clog2(DW + 1);

    logic [DENW-1:0] rem;
    logic [DENW-1:0] den_q;
    logic [CW-1:0]   cnt;
    logic            run;
    logic [DENW:0]   sh;
    logic            ge;

    always_comb begin
        sh = {rem, quo[DW-1]};
        ge = sh >= {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        rdy <= 1'b0;
        if (rst) begin
            run   <= 1'b0;
            cnt   <= '0;
            rem   <= '0;
            quo   <= '0;
            den_q <= '0;
        end else if (go) begin
            quo   <= num;
            den_q <= den;
            rem   <= '0;
            cnt   <= CW'(DW);
            run   <= 1'b1;
        end else if (run) begin
            rem <= ge ? DENW'(sh - {1'b0, den_q}) : sh[DENW-1:0];
            quo <= {quo[DW-2:0], ge};
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
                run <= 1'b0;
                rdy <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bt_step.sv
module bt_step
    import bt_pkg::*;
#(
    parameter int W  = 32,
    parameter int DW = 48
) (
    input  logic          up,
    input  logic          dn,
    input  logic [W-1:0]  boost,
    input  logic [DW-1:0] quo,
    input  logic [W-1:0]  fmax,
    input  bt_en_t        en_in,
    input  logic [W-1:0]  avg,
    input  logic [W-1:0]  dep_thr,
    output logic [W-1:0]  boost_n,
    output bt_en_t        en_n
);
    logic [DW:0] grown;

    always_comb begin
        grown   = {1'b0, quo} + (DW+1)'(STEP_KHZ);
        boost_n = boost;
        en_n    = en_in;
        if (up) begin
            en_n = '{above: 1'b1, below: 1'b1};
            if (grown >= (DW+1)'(fmax)) begin
                boost_n    = fmax;
                en_n.above = 1'b0;
            end else begin
                boost_n = grown[W-1:0];
            end
        end else if (dn) begin
            en_n = '{above: 1'b1, below: 1'b1};
            if (quo < DW'(HALF_STEP)) begin
                boost_n    = '0;
                en_n.below = 1'b0;
            end else begin
                boost_n = quo[W-1:0];
            end
        end
        if (dep_thr != '0) begin
            if (avg >= dep_thr)
                en_n.below = 1'b1;
            else if (boost_n == '0)
                en_n.below = 1'b0;
        end
    end
endmodule

// File: rtl/bt_target_ctrl.sv
module bt_target_ctrl
    import bt_pkg::*;
#(
    parameter int W  = 32,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          ev_up,
    input  logic          ev_dn,
    input  logic          en_above_i,
    input  logic          en_below_i,
    input  logic [W-1:0]  avg_i,
    input  logic [W-1:0]  fmax_i,
    input  logic [W-1:0]  fcur_i,
    input  logic [PW-1:0] up_pct_i,
    input  logic [PW-1:0] dn_pct_i,
    input  logic [PW-1:0] up_thr_i,
    input  logic [PW-1:0] band_i,
    input  logic [W-1:0]  dep_thr_i,
    input  logic [W-1:0]  floor_i,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  target_o,
    output logic [W-1:0]  boost_o,
    output logic          en_above_o,
    output logic          en_below_o,
    output logic [W-1:0]  wm_hi_o,
    output logic [W-1:0]  wm_lo_o
);
    localparam int DW = W + PW;

    bt_state_e      st;
    logic           up_l, dn_l;
    bt_en_t         en_l, en_s, en_n;
    logic [W-1:0]   avg_l, boost_s, boost_n, a12_q;
    logic [PW-1:0]  coef_q;
    logic           div_go, div_rdy;
    logic [DW-1:0]  div_num, div_quo, mul_p;
    logic [PW-1:0]  div_den;
    logic [W-1:0]   mul_a;
    logic [PW-1:0]  mul_b;
    logic [DW:0]    tsum;
    logic [W-1:0]   t_sat, t_fin, band_w, band_max;

    always_comb begin
        mul_a = (st == ST_TMUL) ? a12_q  : boost_q_w();
        mul_b = (st == ST_TMUL) ? coef_q : (up_l ? up_pct_i : dn_pct_i);
    end

    function automatic logic [W-1:0] boost_q_w();
        return boost_o;
    endfunction

    bt_mul #(.W(W), .PW(PW)) u_mul (.a(mul_a), .b(mul_b), .p(mul_p));

    bt_div #(.DW(DW), .DENW(PW)) u_div (
        .clk(clk), .rst(rst), .go(div_go), .num(div_num), .den(div_den),
        .rdy(div_rdy), .quo(div_quo)
    );

    bt_step #(.W(W), .DW(DW)) u_step (
        .up(up_l), .dn(dn_l), .boost(boost_o), .quo(div_quo), .fmax(fmax_i),
        .en_in(en_l), .avg(avg_l), .dep_thr(dep_thr_i),
        .boost_n(boost_n), .en_n(en_n)
    );

    always_comb begin
        tsum     = {1'b0, div_quo} + (DW+1)'(boost_s);
        t_sat    = (tsum[DW:W] != '0) ? '1 : tsum[W-1:0];
        t_fin    = ((avg_l >= dep_thr_i) && (floor_i > t_sat)) ? floor_i : t_sat;
        band_w   = (W'(band_i) << 3) + (W'(band_i) << 2);
        band_max = (avg_l > band_w) ? avg_l : band_w;
    end

    assign busy = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        div_go <= 1'b0;
        done   <= 1'b0;
        if (rst) begin
            st         <= ST_IDLE;
            up_l       <= 1'b0;
            dn_l       <= 1'b0;
            en_l       <= '{above: 1'b1, below: 1'b1};
            en_s       <= '{above: 1'b1, below: 1'b1};
            avg_l      <= '0;
            boost_s    <= '0;
            a12_q      <= '0;
            coef_q     <= '0;
            div_num    <= '0;
            div_den    <= '0;
            boost_o    <= '0;
            target_o   <= fcur_i;
            en_above_o <= 1'b1;
            en_below_o <= 1'b1;
            wm_hi_o    <= '0;
            wm_lo_o    <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    up_l  <= ev_up;
                    dn_l  <= ev_dn;
                    en_l  <= '{above: en_above_i, below: en_below_i};
                    avg_l <= avg_i;
                    st    <= (ev_up || ev_dn) ? ST_BMUL : ST_BUPD;
                end
                ST_BMUL: begin
                    div_go  <= 1'b1;
                    div_num <= mul_p;
                    div_den <= PW'(PCT_BASE);
                    st      <= ST_BDIV;
                end
                ST_BDIV: if (div_rdy) st <= ST_BUPD;
                ST_BUPD: begin
                    boost_s <= boost_n;
                    en_s    <= en_n;
                    div_go  <= 1'b1;
                    div_num <= DW'(avg_l);
                    div_den <= PW'(PERIOD_MS);
                    st      <= ST_ADIV;
                end
                ST_ADIV: if (div_rdy) begin
                    a12_q   <= div_quo[W-1:0];
                    div_go  <= 1'b1;
                    div_num <= DW'(COEF_NUM);
                    div_den <= up_thr_i;
                    st      <= ST_CDIV;
                end
                ST_CDIV: if (div_rdy) begin
                    coef_q <= div_quo[PW-1:0];
                    st     <= ST_TMUL;
                end
                ST_TMUL: begin
                    div_go  <= 1'b1;
                    div_num <= mul_p;
                    div_den <= PW'(PCT_BASE);
                    st      <= ST_TDIV;
                end
                ST_TDIV: if (div_rdy) st <= ST_FIN;
                ST_FIN: begin
                    boost_o    <= boost_s;
                    en_above_o <= en_s.above;
                    en_below_o <= en_s.below;
                    target_o   <= t_fin;
                    wm_hi_o    <= avg_l + band_w;
                    wm_lo_o    <= band_max - band_w;
                    done       <= 1'b1;
                    st         <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bt_target_ctrl_chk.sv
module bt_target_ctrl_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] avg_i,
    input logic [W-1:0] fmax_i,
    input logic [W-1:0] dep_thr_i,
    input logic [W-1:0] floor_i,
    input logic [W-1:0] target_o,
    input logic [W-1:0] boost_o,
    input logic [W-1:0] wm_lo_o
);
    a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r1_busy_rise: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r1_hold_boost: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(boost_o));

    a_r1_hold_target: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(target_o));

    a_r3_boost_cap: assert property (@(posedge clk) disable iff (rst)
        done |-> boost_o <= fmax_i);

    a_r8_lo_mark: assert property (@(posedge clk) disable iff (rst)
        done |-> wm_lo_o <= avg_i);

    a_r10_floor: assert property (@(posedge clk) disable iff (rst)
        (done && avg_i >= dep_thr_i) |-> target_o >= floor_i);
endmodule

bind bt_target_ctrl bt_target_ctrl_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .avg_i(avg_i), .fmax_i(fmax_i), .dep_thr_i(dep_thr_i), .floor_i(floor_i),
    .target_o(target_o), .boost_o(boost_o), .wm_lo_o(wm_lo_o)
);

// File: tb/sim_bt_target_ctrl.sv
module sim_bt_target_ctrl;
    localparam int W  = 32;
    localparam int PW = 16;
    localparam longint MASK = 64'hFFFF_FFFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, ev_up = 1'b0, ev_dn = 1'b0;
    logic en_above_i = 1'b1, en_below_i = 1'b1;
    logic [W-1:0]  avg_i = 0, fmax_i = 1000000, fcur_i = 333000;
    logic [PW-1:0] up_pct_i = 200, dn_pct_i = 50, up_thr_i = 60, band_i = 800;
    logic [W-1:0]  dep_thr_i = 0, floor_i = 0;
    logic busy, done, en_above_o, en_below_o;
    logic [W-1:0] target_o, boost_o, wm_hi_o, wm_lo_o;

    int checks = 0, errors = 0;
    longint m_boost = 0;
    longint cyc = 0;

    always #4 clk = ~clk;

    bt_target_ctrl #(.W(W), .PW(PW)) u0 (
        .clk(clk), .rst(rst), .start(start), .ev_up(ev_up), .ev_dn(ev_dn),
        .en_above_i(en_above_i), .en_below_i(en_below_i), .avg_i(avg_i),
        .fmax_i(fmax_i), .fcur_i(fcur_i), .up_pct_i(up_pct_i), .dn_pct_i(dn_pct_i),
        .up_thr_i(up_thr_i), .band_i(band_i), .dep_thr_i(dep_thr_i), .floor_i(floor_i),
        .busy(busy), .done(done), .target_o(target_o), .boost_o(boost_o),
        .en_above_o(en_above_o), .en_below_o(en_below_o),
        .wm_hi_o(wm_hi_o), .wm_lo_o(wm_lo_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    // One update: model, drive, wait for done, compare. extra_start pokes start mid-run.
    task automatic do_op(input logic up, input logic dn, input bit extra_start);
        longint q, s, nb, band, hi, lo, t, avg;
        logic ea, eb;
        int n;
        longint b0, t0;
        bit held;
        avg = longint'(avg_i);
        ea = en_above_i; eb = en_below_i; nb = m_boost;
        if (up) begin
            q = (m_boost * longint'(up_pct_i)) / 100;
            s = q + 16000; ea = 1; eb = 1;
            if (s >= longint'(fmax_i)) begin nb = longint'(fmax_i); ea = 0; end
            else nb = s;
        end else if (dn) begin
            q = (m_boost * longint'(dn_pct_i)) / 100;
            ea = 1; eb = 1;
            if (q < 8000) begin nb = 0; eb = 0; end
            else nb = q & MASK;
        end
        if (dep_thr_i != 0) begin
            if (avg >= longint'(dep_thr_i)) eb = 1;
            else if (nb == 0) eb = 0;
        end
        band = longint'(band_i) * 12;
        hi = (avg + band) & MASK;
        lo = ((avg > band) ? avg : band) - band;
        t = ((avg / 12) * (10000 / longint'(up_thr_i))) / 100 + nb;
        if (t > MASK) t = MASK;
        if (avg >= longint'(dep_thr_i) && longint'(floor_i) > t) t = longint'(floor_i);

        @(negedge clk);
        ev_up = up; ev_dn = dn; start = 1'b1;
        b0 = longint'(boost_o); t0 = longint'(target_o);
        @(negedge clk);
        start = 1'b0;
        chk("R1 busy after start", longint'(busy), 1);
        n = 0; held = 1;
        while (!done && n < 3000) begin
            if (extra_start && n == 3) start = 1'b1;
            if (extra_start && n == 4) start = 1'b0;
            if (longint'(boost_o) != b0 || longint'(target_o) != t0) held = 0;
            @(negedge clk);
            n++;
        end
        chk("R1 done arrives", longint'(done), 1);
        chk("R1 outputs held while busy", longint'(held), 1);
        if (up) chk("R2/R3/R5 boost after upward event", longint'(boost_o), nb);
        else if (dn) chk("R4 boost after downward event", longint'(boost_o), nb);
        else chk("R6 boost kept", longint'(boost_o), nb);
        chk("R2 R3 R6 above-enable", longint'(en_above_o), longint'(ea));
        chk("R4 R6 R7 below-enable", longint'(en_below_o), longint'(eb));
        chk("R8 high watermark", longint'(wm_hi_o), hi);
        chk("R8 low watermark", longint'(wm_lo_o), lo);
        chk("R9 R10 target", longint'(target_o), t);
        m_boost = nb;
        @(negedge clk);
        chk("R1 done single cycle", longint'(done), 0);
        ev_up = 0; ev_dn = 0;
    endtask

    initial begin
        int seen;
        void'($urandom(7));
        repeat (3) @(negedge clk);
        // R11 reset values
        chk("R11 boost reset", longint'(boost_o), 0);
        chk("R11 target follows fcur", longint'(target_o), 333000);
        chk("R11 enables reset", longint'({en_above_o, en_below_o}), 3);
        chk("R11 done idle", longint'({done, busy}), 0);
        chk("R11 watermarks reset", longint'(wm_hi_o | wm_lo_o), 0);
        rst = 1'b0;
        @(negedge clk);

        // R2 growth, then R3 clamp
        avg_i = 200000;
        do_op(1, 0, 0);
        do_op(1, 0, 0);
        fmax_i = 60000;
        do_op(1, 0, 0);
        chk("R3 clamped to fmax", longint'(boost_o), 60000);
        chk("R3 above-enable off", longint'(en_above_o), 0);
        // R4 decay to zero
        do_op(0, 1, 0);
        do_op(0, 1, 0);
        do_op(0, 1, 0);
        chk("R4 boost zero", longint'(boost_o), 0);
        chk("R4 below-enable off", longint'(en_below_o), 0);
        // R5 priority
        fmax_i = 1000000;
        do_op(1, 1, 0);
        chk("R5 upward wins", longint'(boost_o), 16000);
        // R6 passthrough
        en_above_i = 0; en_below_i = 1;
        do_op(0, 0, 0);
        en_above_i = 1; en_below_i = 0;
        do_op(0, 0, 0);
        // R7 and R10 dependency
        up_pct_i = 800; dn_pct_i = 90; up_thr_i = 27; dep_thr_i = 50000;
        avg_i = 60000; floor_i = 900000; en_below_i = 0;
        do_op(0, 0, 0);
        chk("R7 below forced on", longint'(en_below_o), 1);
        chk("R10 floor applied", longint'(target_o), 900000);
        avg_i = 1000; en_below_i = 1;
        do_op(0, 1, 0);
        do_op(0, 1, 0);
        do_op(0, 1, 0);
        // R8 band larger than average
        band_i = 5000; avg_i = 100;
        do_op(0, 0, 0);
        // R1 start during busy ignored
        do_op(1, 0, 1);
        seen = 0;
        repeat (600) begin
            @(negedge clk);
            if (done) seen++;
        end
        chk("R1 start while busy ignored", longint'(seen), 0);

        // constrained random
        for (int i = 0; i < 40; i++) begin
            logic u, d;
            u = ($urandom % 3) == 0;
            d = ($urandom % 3) == 0;
            avg_i      = $urandom % 3000000;
            fmax_i     = 100000 + ($urandom % 1900000);
            up_pct_i   = PW'(100 + ($urandom % 800));
            dn_pct_i   = PW'(10 + ($urandom % 91));
            up_thr_i   = PW'(5 + ($urandom % 86));
            band_i     = PW'($urandom % 20000);
            dep_thr_i  = ($urandom % 2) ? 50000 : 0;
            floor_i    = $urandom % 1000000;
            en_above_i = $urandom % 2;
            en_below_i = $urandom % 2;
            if (m_boost > longint'(fmax_i)) fmax_i = W'(m_boost);
            do_op(u, d, 0);
        end
        finish_run();
    end
endmodule